// File: doc/BRIEF.md
# Interrupt Context Stack Save and Restore Sequencer

When an interrupt is accepted, this block pushes the processor's minimal context onto a byte-addressed stack that grows downward. The context is the 20-bit program counter and the 16-bit flag word. Software saves every other register itself. A save captures the current PC, flags and stack pointer. It then issues two 16-bit writes. The first write is a packed word that holds the flag priority nibble, the top four PC bits and the low flag byte. The second write holds the lower sixteen PC bits. The block then reports the new stack pointer together with a one-cycle completion pulse.

The restore sequence does the reverse. It reads the PC low word at the stack pointer, then reads the packed word two bytes above it. It rebuilds the PC and the flag word and moves the stack pointer up by four. The four middle flag bits are not part of the frame, so they come back as zero. The memory side is a simple strobe/ready handshake. Each strobe keeps its address and data steady until ready is seen. Words are little-endian: the low byte sits at the lower address.

Top module: `irq_ctx_stacker`

## Requirements
- R1: After a save request with stack pointer m, the first write goes to address m-2 with data bits 15:12 = flag 15:12, bits 11:8 = PC 19:16, bits 7:0 = flag 7:0. So byte m-1 holds {flag priority nibble, PC high nibble} and byte m-2 holds the low flag byte.
- R2: The second write of a save goes to address m-4 with data = PC 15:0. It is issued only after the first write has seen ready.
- R3: While mem_wr or mem_rd is high and mem_ready is low, the strobe, mem_addr and mem_wdata hold their values. mem_wr and mem_rd are never high together.
- R4: In the cycle after the final write sees ready, sp_out becomes m-4 and done is high for exactly one cycle. A save leaves pc_out and flg_out unchanged.
- R5: A restore request with stack pointer s reads address s first. After that read sees ready, it reads address s+2.
- R6: When a restore completes, pc_out = {second word 11:8, first word}, flg_out = {second word 15:12, 4'b0000, second word 7:0} and sp_out = s+4. done pulses for one cycle. Stack addresses wrap modulo 2^16.
- R7: A save or restore request that arrives while a sequence is in progress is ignored. It causes no memory access and no change at the outputs.
- R8: If save and restore requests arrive in the same idle cycle, only the save runs.
- R9: Under reset, mem_wr, mem_rd and done are low, and sp_out, pc_out and flg_out are zero.
- R10: The PC, flags and stack pointer are captured in the request cycle. Changes on pc_in, flg_in and sp_in during a sequence have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Start a context save (pulse) |
| restore_req | input | 1 | Start a context restore (pulse) |
| pc_in | input | 20 | Program counter to save |
| flg_in | input | 16 | Flag word to save |
| sp_in | input | 16 | Current stack pointer |
| mem_wr | output | 1 | Write strobe to stack memory |
| mem_rd | output | 1 | Read strobe to stack memory |
| mem_addr | output | 16 | Byte address of the 16-bit access |
| mem_wdata | output | 16 | Write data, low byte at mem_addr |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current access |
| sp_out | output | 16 | Stack pointer after the last sequence |
| pc_out | output | 20 | Program counter from the last restore |
| flg_out | output | 16 | Flag word from the last restore |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state appears on the memory port. It shows up at once as a strobe that should not be there, an address offset that is off by two, or a missing second access. A scoreboard that expects an exact sequence of accesses catches any of these at the next ready handshake. A packing error in the frame does not show during the save itself. It appears one sequence later, when the restore returns swapped nibbles or wrong middle flag bits on pc_out and flg_out. Tests with a wait of zero cycles and tests with a long wait separate errors in the strobe-holding logic from errors in the ordering.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  localparam int WORD_W   = 16;
  localparam int IPL_W    = 4;
  localparam int FLGLO_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_HI = 3'd1,
    ST_PUSH_LO = 3'd2,
    ST_POP_LO  = 3'd3,
    ST_POP_HI  = 3'd4
  } ctx_state_e;

endpackage

// File: rtl/ctx_rst_sync.sv
module ctx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);

  logic [1:0] sync_q;

  // asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign core_rst_n = sync_q[1];

endmodule

// File: rtl/ctx_frame_codec.sv
module ctx_frame_codec
  import ctx_stack_pkg::*;
#(
  parameter int PC_W  = 20,
  parameter int FLG_W = 16
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [FLG_W-1:0]  flg,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  output logic [WORD_W-1:0] push_hi,
  output logic [WORD_W-1:0] push_lo,
  output logic [PC_W-1:0]   pop_pc,
  output logic [FLG_W-1:0]  pop_flg
);

  localparam int PCH_W = PC_W - WORD_W;
  localparam int MID_W = FLG_W - IPL_W - FLGLO_W;

  // packed word: priority nibble on top, PC high bits, then low flag byte
  assign push_hi = {flg[FLG_W-1 -: IPL_W], pc[PC_W-1 -: PCH_W], flg[FLGLO_W-1:0]};
  assign push_lo = pc[WORD_W-1:0];

  assign pop_pc  = {hi_word[FLGLO_W +: PCH_W], lo_word};
  assign pop_flg = {hi_word[WORD_W-1 -: IPL_W], {MID_W{1'b0}}, hi_word[FLGLO_W-1:0]};

endmodule

// File: rtl/ctx_stack_fsm.sv
module ctx_stack_fsm
  import ctx_stack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic save_req,
  input  logic restore_req,
  input  logic mem_ready,
  output logic ld_ctx,
  output logic capt_lo,
  output logic fin_save,
  output logic fin_rest,
  output logic is_wr,
  output logic is_rd,
  output logic second
);

  ctx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (save_req)         state_d = ST_PUSH_HI;
        else if (restore_req) state_d = ST_POP_LO;
      end
      ST_PUSH_HI: if (mem_ready) state_d = ST_PUSH_LO;
      ST_PUSH_LO: if (mem_ready) state_d = ST_IDLE;
      ST_POP_LO:  if (mem_ready) state_d = ST_POP_HI;
      ST_POP_HI:  if (mem_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // requests only count while idle; save takes precedence
  assign ld_ctx   = (state_q == ST_IDLE) && (save_req || restore_req);
  assign is_wr    = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO);
  assign is_rd    = (state_q == ST_POP_LO)  || (state_q == ST_POP_HI);
  assign second   = (state_q == ST_PUSH_LO) || (state_q == ST_POP_HI);
  assign capt_lo  = (state_q == ST_POP_LO)  && mem_ready;
  assign fin_save = (state_q == ST_PUSH_LO) && mem_ready;
  assign fin_rest = (state_q == ST_POP_HI)  && mem_ready;

endmodule

// File: rtl/ctx_stack_dp.sv
module ctx_stack_dp
  import ctx_stack_pkg::*;
#(
  parameter int SP_W  = 16,
  parameter int PC_W  = 20,
  parameter int FLG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ctx,
  input  logic              capt_lo,
  input  logic              fin_save,
  input  logic              fin_rest,
  input  logic              is_wr,
  input  logic              is_rd,
  input  logic              second,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [FLG_W-1:0]  flg_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [SP_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [SP_W-1:0]   sp_out,
  output logic [PC_W-1:0]   pc_out,
  output logic [FLG_W-1:0]  flg_out,
  output logic              done
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam logic [SP_W-1:0] STEP1 = SP_W'(WORD_BYTES);
  localparam logic [SP_W-1:0] STEP2 = SP_W'(2 * WORD_BYTES);

  logic [SP_W-1:0]   base_q;
  logic [PC_W-1:0]   pc_q;
  logic [FLG_W-1:0]  flg_q;
  logic [WORD_W-1:0] lo_q;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic [PC_W-1:0]   pco_q;
  logic [FLG_W-1:0]  flgo_q;
  logic              done_q, done_d;
  logic              sp_en;

  logic [WORD_W-1:0] push_hi, push_lo;
  logic [PC_W-1:0]   pop_pc;
  logic [FLG_W-1:0]  pop_flg;

  ctx_frame_codec #(.PC_W(PC_W), .FLG_W(FLG_W)) u_codec (
    .pc      (pc_q),
    .flg     (flg_q),
    .lo_word (lo_q),
    .hi_word (mem_rdata),
    .push_hi (push_hi),
    .push_lo (push_lo),
    .pop_pc  (pop_pc),
    .pop_flg (pop_flg)
  );

  // next-state of the committed outputs
  always_comb begin
    sp_en  = fin_save || fin_rest;
    sp_d   = fin_save ? (base_q - STEP2) : (base_q + STEP2);
    done_d = fin_save || fin_rest;
  end

  // access address and data
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    if (is_wr) begin
      mem_addr  = second ? (base_q - STEP2) : (base_q - STEP1);
      mem_wdata = second ? push_lo : push_hi;
    end else if (is_rd) begin
      mem_addr  = second ? (base_q + STEP1) : base_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pc_q   <= '0;
      flg_q  <= '0;
    end else if (ld_ctx) begin
      base_q <= sp_in;
      pc_q   <= pc_in;
      flg_q  <= flg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_q <= '0;
    else if (capt_lo) lo_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pco_q  <= '0;
      flgo_q <= '0;
    end else if (fin_rest) begin
      pco_q  <= pop_pc;
      flgo_q <= pop_flg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign sp_out  = sp_q;
  assign pc_out  = pco_q;
  assign flg_out = flgo_q;
  assign done    = done_q;

endmodule

// File: rtl/irq_ctx_stacker.sv
module irq_ctx_stacker #(
  parameter int SP_W  = 16,
  parameter int PC_W  = 20,
  parameter int FLG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [FLG_W-1:0] flg_in,
  input  logic [SP_W-1:0]  sp_in,
  output logic             mem_wr,
  output logic             mem_rd,
  output logic [SP_W-1:0]  mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_ready,
  output logic [SP_W-1:0]  sp_out,
  output logic [PC_W-1:0]  pc_out,
  output logic [FLG_W-1:0] flg_out,
  output logic             done
);

  logic core_rst_n;
  logic ld_ctx, capt_lo, fin_save, fin_rest, is_wr, is_rd, second;

  ctx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  ctx_stack_fsm u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .mem_ready   (mem_ready),
    .ld_ctx      (ld_ctx),
    .capt_lo     (capt_lo),
    .fin_save    (fin_save),
    .fin_rest    (fin_rest),
    .is_wr       (is_wr),
    .is_rd       (is_rd),
    .second      (second)
  );

  ctx_stack_dp #(.SP_W(SP_W), .PC_W(PC_W), .FLG_W(FLG_W)) u_dp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .ld_ctx    (ld_ctx),
    .capt_lo   (capt_lo),
    .fin_save  (fin_save),
    .fin_rest  (fin_rest),
    .is_wr     (is_wr),
    .is_rd     (is_rd),
    .second    (second),
    .pc_in     (pc_in),
    .flg_in    (flg_in),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_out    (sp_out),
    .pc_out    (pc_out),
    .flg_out   (flg_out),
    .done      (done)
  );

  assign mem_wr = is_wr;
  assign mem_rd = is_rd;

endmodule

// File: rtl/irq_ctx_stacker_chk.sv
module irq_ctx_stacker_chk #(
  parameter int SP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SP_W-1:0] sp_in,
  input logic            mem_wr,
  input logic            mem_rd,
  input logic [SP_W-1:0] mem_addr,
  input logic [15:0]     mem_wdata,
  input logic            mem_ready,
  input logic [SP_W-1:0] sp_out,
  input logic            done
);

  // R1
  first_push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> mem_addr == ($past(sp_in) - SP_W'(2)));

  // R2
  second_push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr && mem_ready)) |-> mem_addr == ($past(mem_addr) - SP_W'(2)));

  // R5
  first_pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> mem_addr == $past(sp_in));

  // R5
  second_pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd && mem_ready)) |-> mem_addr == ($past(mem_addr) + SP_W'(2)));

  // R3
  hold_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  // R3
  hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  // R3
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_ready) && (sp_out != $past(sp_out))));

endmodule

bind irq_ctx_stacker irq_ctx_stacker_chk #(.SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sp_in     (sp_in),
  .mem_wr    (mem_wr),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .sp_out    (sp_out),
  .done      (done)
);

// File: tb/test_irq_ctx_stacker.sv
module test_irq_ctx_stacker;

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [15:0] data;
    string       req;
  } bus_item_t;

  typedef struct {
    logic [15:0] sp;
    logic [19:0] pc;
    logic [15:0] flg;
    string       req;
  } done_item_t;

  logic        clk;
  logic        rst_n;
  logic        save_req, restore_req;
  logic [19:0] pc_in;
  logic [15:0] flg_in, sp_in;
  logic        mem_wr, mem_rd, mem_ready, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, sp_out, flg_out;
  logic [19:0] pc_out;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 0;
  int done_cnt = 0;

  bus_item_t  bus_q[$];
  done_item_t done_q[$];
  logic [7:0] smem [logic [15:0]];
  logic [19:0] mdl_pc;
  logic [15:0] mdl_flg;

  irq_ctx_stacker i_irq_ctx_stacker (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .pc_in(pc_in), .flg_in(flg_in), .sp_in(sp_in),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .sp_out(sp_out), .pc_out(pc_out), .flg_out(flg_out), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rdb(logic [15:0] a);
    if (smem.exists(a)) return smem[a];
    return 8'h00;
  endfunction

  // memory responder and bus monitor
  initial begin
    int          wcnt = 0;
    logic [15:0] a0, d0;
    bit          stab;
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      if (rst_n && (mem_wr || mem_rd)) begin
        if (wcnt == 0) begin
          a0 = mem_addr; d0 = mem_wdata; stab = 1'b1;
        end else if (mem_addr !== a0 || (mem_wr && mem_wdata !== d0)) begin
          stab = 1'b0;
        end
        if (wcnt >= lat) begin
          n_checks++;
          if (!stab) begin
            n_fail++;
            $display("FAIL R3 access changed while waiting: actual addr=%h data=%h expected addr=%h data=%h",
                     mem_addr, mem_wdata, a0, d0);
          end
          n_checks++;
          if (bus_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 unexpected access: actual wr=%0b addr=%h expected none", mem_wr, mem_addr);
          end else begin
            bus_item_t it;
            it = bus_q.pop_front();
            if (it.wr !== mem_wr || it.addr !== mem_addr || (it.wr && it.data !== mem_wdata)) begin
              n_fail++;
              $display("FAIL %s access: actual wr=%0b addr=%h data=%h expected wr=%0b addr=%h data=%h",
                       it.req, mem_wr, mem_addr, mem_wdata, it.wr, it.addr, it.data);
            end
          end
          if (mem_wr) begin
            smem[mem_addr]         = mem_wdata[7:0];
            smem[mem_addr + 16'd1] = mem_wdata[15:8];
          end else begin
            mem_rdata = {rdb(mem_addr + 16'd1), rdb(mem_addr)};
          end
          mem_ready = 1'b1;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  // completion monitor
  initial begin
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        done_cnt++;
        n_checks++;
        if (prev) begin
          n_fail++;
          $display("FAIL R4 done longer than one cycle: actual=1 expected=0");
        end
        n_checks++;
        if (done_q.size() == 0) begin
          n_fail++;
          $display("FAIL R7 unexpected done: actual=1 expected=0");
        end else begin
          done_item_t e;
          e = done_q.pop_front();
          if (sp_out !== e.sp || pc_out !== e.pc || flg_out !== e.flg) begin
            n_fail++;
            $display("FAIL %s result: actual sp=%h pc=%h flg=%h expected sp=%h pc=%h flg=%h",
                     e.req, sp_out, pc_out, flg_out, e.sp, e.pc, e.flg);
          end
        end
      end
      prev = done;
    end
  end

  task automatic kick(bit s, bit r, logic [19:0] pc, logic [15:0] flg, logic [15:0] sp);
    @(negedge clk);
    save_req = s; restore_req = r; pc_in = pc; flg_in = flg; sp_in = sp;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    // R10: scramble the inputs once the request is taken
    pc_in = ~pc; flg_in = ~flg; sp_in = sp ^ 16'h5A5A;
  endtask

  task automatic exp_save(logic [19:0] pc, logic [15:0] flg, logic [15:0] sp);
    bus_q.push_back('{1'b1, sp - 16'd2, {flg[15:12], pc[19:16], flg[7:0]}, "R1"});
    bus_q.push_back('{1'b1, sp - 16'd4, pc[15:0], "R2"});
    done_q.push_back('{sp - 16'd4, mdl_pc, mdl_flg, "R4"});
  endtask

  task automatic exp_restore(logic [15:0] sp);
    logic [15:0] lo, hi;
    lo = {rdb(sp + 16'd1), rdb(sp)};
    hi = {rdb(sp + 16'd3), rdb(sp + 16'd2)};
    bus_q.push_back('{1'b0, sp, 16'h0, "R5"});
    bus_q.push_back('{1'b0, sp + 16'd2, 16'h0, "R5"});
    mdl_pc  = {hi[11:8], lo};
    mdl_flg = {hi[15:12], 4'b0000, hi[7:0]};
    done_q.push_back('{sp + 16'd4, mdl_pc, mdl_flg, "R6"});
  endtask

  task automatic wait_done(int n0);
    while (done_cnt == n0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_save(int l, logic [19:0] pc, logic [15:0] flg, logic [15:0] sp);
    int n0;
    lat = l; n0 = done_cnt;
    exp_save(pc, flg, sp);
    kick(1'b1, 1'b0, pc, flg, sp);
    wait_done(n0);
  endtask

  task automatic do_restore(int l, logic [15:0] sp);
    int n0;
    lat = l; n0 = done_cnt;
    exp_restore(sp);
    kick(1'b0, 1'b1, 20'h0, 16'h0, sp);
    wait_done(n0);
  endtask

  task automatic run_tests();
    int n0;
    // R9 reset state
    n_checks++;
    if (mem_wr !== 1'b0 || mem_rd !== 1'b0 || done !== 1'b0 ||
        sp_out !== 16'h0 || pc_out !== 20'h0 || flg_out !== 16'h0) begin
      n_fail++;
      $display("FAIL R9 reset: actual wr=%b rd=%b done=%b sp=%h pc=%h flg=%h expected all zero",
               mem_wr, mem_rd, done, sp_out, pc_out, flg_out);
    end
    // R1 R2 R4 R10 saves with and without wait cycles
    do_save(0, 20'hA5C3E, 16'hB35D, 16'h1000);
    do_save(3, 20'h1F00D, 16'h4CA7, 16'h2000);
    // R6 restores: middle flag bits return as zero
    do_restore(2, 16'h0FFC);
    do_restore(1, 16'h1FFC);
    // R6 wrap on restore
    smem[16'hFFFC] = 8'h34; smem[16'hFFFD] = 8'h12;
    smem[16'hFFFE] = 8'hC9; smem[16'hFFFF] = 8'h7E;
    do_restore(0, 16'hFFFC);
    // R2 wrap on save
    do_save(1, 20'h6789A, 16'hF00F, 16'h0002);
    // R7 requests while busy are ignored
    lat = 4; n0 = done_cnt;
    exp_save(20'h0BEEF, 16'h9A61, 16'h3000);
    kick(1'b1, 1'b0, 20'h0BEEF, 16'h9A61, 16'h3000);
    kick(1'b0, 1'b1, 20'h11111, 16'h2222, 16'h4000);
    kick(1'b1, 1'b0, 20'h33333, 16'h4444, 16'h5000);
    wait_done(n0);
    // R8 simultaneous requests: save wins
    lat = 0; n0 = done_cnt;
    exp_save(20'hFEDCB, 16'h7E81, 16'h0800);
    kick(1'b1, 1'b1, 20'hFEDCB, 16'h7E81, 16'h0800);
    wait_done(n0);
    // R6 restore the frame written under the busy test
    do_restore(2, 16'h2FFC);
    repeat (20) @(negedge clk);
    // R7 nothing left over or extra
    n_checks++;
    if (bus_q.size() != 0 || done_q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 leftover expectations: actual bus=%0d done=%0d expected 0 0",
               bus_q.size(), done_q.size());
    end
  endtask

  initial begin
    save_req = 1'b0; restore_req = 1'b0;
    pc_in = '0; flg_in = '0; sp_in = '0;
    mdl_pc = '0; mdl_flg = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule